// File: doc/BRIEF.md
# DMA Fault Status Capture Unit

This block sits beside an address translator for DMA traffic and records the first failing translated access. When the translator signals a fault, the unit packs four things into one held 64-bit status word: the fault kind (segment or page), the page address, the transfer direction and the requester ID. It then holds that word until software acknowledges it. Faults that arrive while a record is held are dropped, so software always sees the earliest one.

A second register holds two enables, one for each fault kind. The interrupt output is raised while a record is held and the enable for that record's kind is set. Software reads either register through a simple register port. It acknowledges a record by writing the status word back with the valid bit zero. During bring-up, software first clears any stale record and then enables both kinds.

Top module: `dma_fault_capture`

## Requirements
- R1: After reset the status word reads 0, the mask word reads 0 and `irqOut` is low.
- R2: A `faultValid` pulse while no record is held sets status bit 63 (valid), visible in the cycle after the pulse's clock edge.
- R3: Status bits 62:61 hold the fault kind: 2'b11 for a segment fault (`faultSeg`=1) and 2'b10 for a page fault (`faultSeg`=0).
- R4: Status bits 34:12 hold `faultPage`, bit 11 holds `faultRead` (1 = read, 0 = write) and bits 10:0 hold `faultReqId`. Bits 60:35 read 0.
- R5: While valid is set, later fault pulses leave every status bit unchanged.
- R6: A write to the status register (`regSel`=0) with data bit 63 at 0 clears valid and keeps bits 62:0. A status write with data bit 63 at 1 changes nothing.
- R7: When a fault pulse and a clearing status write fall in the same cycle, the new fault is captured and valid stays set.
- R8: A write to the mask register (`regSel`=1) stores data bit 62 (segment enable) and bit 61 (page enable). All other mask bits read 0.
- R9: `irqOut` is high exactly when valid is set and the mask enable for the captured kind is set. Bit 62 enables segment faults and bit 61 enables page faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | One-cycle fault report from the translator |
| faultSeg | input | 1 | Fault kind: 1 segment, 0 page |
| faultPage | input | 23 | Page address of the failing access |
| faultRead | input | 1 | Direction: 1 read, 0 write |
| faultReqId | input | 11 | Requester ID of the failing access |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 status, 1 mask |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data of the selected register |
| irqOut | output | 1 | Fault interrupt |

## Verification
The case that needs the most care is a translator fault and a software clear landing in the same cycle. A clear that runs after the capture would lose the new record. The bench provokes this by driving a fresh page fault together with a status write whose bit 63 is 0, while an older record is still held. It then expects the next status read to show the new page, direction and requester ID with valid set, and the interrupt to follow the page enable. Mask writes that coincide with a held record are also mixed in, so that the interrupt's response to an enable change is judged against the captured kind.

// File: rtl/fault_cap_pkg.sv
package fault_cap_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic capture;     // load a new fault record, set valid
    logic clearValid;  // software acknowledges the held record
    logic maskWrite;   // load the interrupt enables
  } ctrlStrobes_t;

endpackage

// File: rtl/fault_cap_ctrl.sv
module fault_cap_ctrl
  import fault_cap_pkg::*;
(
  input  logic         faultValid,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         wrValidBit,
  input  logic         validQ,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.clearValid = regWrEn && !regSel && !wrValidBit;
    // a new fault wins over a clear in the same cycle
    strobes.capture    = faultValid && (!validQ || strobes.clearValid);
    strobes.maskWrite  = regWrEn && regSel;
  end

endmodule

// File: rtl/fault_cap_dp.sv
module fault_cap_dp
  import fault_cap_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int PAGE_W = 23,
  parameter int ID_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              faultSeg,
  input  logic [PAGE_W-1:0] faultPage,
  input  logic              faultRead,
  input  logic [ID_W-1:0]   faultReqId,
  input  logic [WORD_W-1:0] maskIn,
  output logic              validQ,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] maskWord,
  output logic              irq
);

  localparam int VALID_BIT = WORD_W - 1;
  localparam int KIND_HI   = WORD_W - 2;
  localparam int KIND_LO   = WORD_W - 3;
  localparam int DIR_BIT   = ID_W;
  localparam int PAGE_LO   = ID_W + 1;
  localparam logic [WORD_W-1:0] MASK_KEEP =
    (WORD_W'(1) << KIND_HI) | (WORD_W'(1) << KIND_LO);

  logic [1:0]        kindQ;
  logic [PAGE_W-1:0] pageQ;
  logic              readQ;
  logic [ID_W-1:0]   idQ;
  logic [WORD_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      kindQ  <= 2'b00;
      pageQ  <= '0;
      readQ  <= 1'b0;
      idQ    <= '0;
    end else if (strobes.capture) begin
      validQ <= 1'b1;
      kindQ  <= {1'b1, faultSeg};
      pageQ  <= faultPage;
      readQ  <= faultRead;
      idQ    <= faultReqId;
    end else if (strobes.clearValid) begin
      validQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  maskQ <= '0;
    else if (strobes.maskWrite) maskQ <= maskIn & MASK_KEEP;
  end

  always_comb begin
    statusWord                        = '0;
    statusWord[VALID_BIT]             = validQ;
    statusWord[KIND_HI:KIND_LO]       = kindQ;
    statusWord[PAGE_LO +: PAGE_W]     = pageQ;
    statusWord[DIR_BIT]               = readQ;
    statusWord[ID_W-1:0]              = idQ;
  end

  assign maskWord = maskQ;
  assign irq = validQ && (kindQ[0] ? maskQ[KIND_HI] : maskQ[KIND_LO]);

  // R5: a held record is frozen until software clears it
  a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !strobes.clearValid) |=>
      ($stable(pageQ) && $stable(idQ) && $stable(readQ) && $stable(kindQ) && validQ));

endmodule

// File: rtl/dma_fault_capture.sv
module dma_fault_capture
  import fault_cap_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int PAGE_W = 23,
  parameter int ID_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic              faultSeg,
  input  logic [PAGE_W-1:0] faultPage,
  input  logic              faultRead,
  input  logic [ID_W-1:0]   faultReqId,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int VALID_BIT = WORD_W - 1;

  ctrlStrobes_t      strobes;
  logic              statusValid;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] maskWord;

  fault_cap_ctrl u_ctrl (
    .faultValid (faultValid),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .wrValidBit (regWrData[VALID_BIT]),
    .validQ     (statusValid),
    .strobes    (strobes)
  );

  fault_cap_dp #(
    .WORD_W (WORD_W),
    .PAGE_W (PAGE_W),
    .ID_W   (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .faultSeg   (faultSeg),
    .faultPage  (faultPage),
    .faultRead  (faultRead),
    .faultReqId (faultReqId),
    .maskIn     (regWrData),
    .validQ     (statusValid),
    .statusWord (statusWord),
    .maskWord   (maskWord),
    .irq        (irqOut)
  );

  assign regRdData = regSel ? maskWord : statusWord;

  // R2: a fault with nothing held becomes a held record
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !statusValid) |=> statusValid);

  // R6: a clearing write with no fault drops valid
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && !regWrData[VALID_BIT] && !faultValid) |=> !statusValid);

  // R7: a fault beside a clearing write is still captured
  a_r7_fault_wins: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && regWrEn && !regSel && !regWrData[VALID_BIT]) |=> statusValid);

  // R9: the interrupt only rises after a fault or a register write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(faultValid || regWrEn));

endmodule

// File: tb/test_dma_fault_capture.sv
module test_dma_fault_capture;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0, faultSeg = 1'b0, faultRead = 1'b0;
  logic [22:0] faultPage = '0;
  logic [10:0] faultReqId = '0;
  logic        regWrEn = 1'b0, regSel = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_fault_capture i_dma_fault_capture (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultSeg(faultSeg),
    .faultPage(faultPage), .faultRead(faultRead), .faultReqId(faultReqId),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct {
    int          due;
    logic        sel;
    logic [63:0] rd;
    logic        irq;
    string       tag;
  } item_t;

  item_t q[$];
  int cycleCnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] mStatus = '0;
  logic [63:0] mMask = '0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // monitor: compares results once they are due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cycleCnt) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (regRdData !== it.rd) begin
          errors++;
          $display("FAIL %s: %s read actual=%h expected=%h", it.tag,
                   it.sel ? "mask" : "status", regRdData, it.rd);
        end
        checks++;
        if (irqOut !== it.irq) begin
          errors++;
          $display("FAIL %s: irq actual=%b expected=%b", it.tag, irqOut, it.irq);
        end
      end
    end
  end

  function automatic logic modelIrq();
    return mStatus[63] && (mStatus[62:61] == 2'b11 ? mMask[62] : mMask[61]);
  endfunction

  // driver: one stimulus cycle, then an idle read cycle; pushes the expectation
  task automatic doCycle(input logic wr, input logic sel, input logic [63:0] wd,
                         input logic fv, input logic seg, input logic [22:0] pg,
                         input logic rd, input logic [10:0] id,
                         input logic rsel, input string tag);
    logic clr;
    item_t it;
    @(negedge clk);
    regWrEn = wr; regSel = sel; regWrData = wd;
    faultValid = fv; faultSeg = seg; faultPage = pg; faultRead = rd; faultReqId = id;
    clr = wr && !sel && !wd[63];
    if (wr && sel) mMask = wd & 64'h6000_0000_0000_0000;
    if (fv && (!mStatus[63] || clr))
      mStatus = {1'b1, (seg ? 2'b11 : 2'b10), 26'b0, pg, rd, id};
    else if (clr)
      mStatus[63] = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; faultValid = 1'b0; regSel = rsel;
    it.due = cycleCnt; it.sel = rsel;
    it.rd = rsel ? mMask : mStatus;
    it.irq = modelIrq();
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state of both registers and the interrupt
    regSel = 1'b0;
    #1;
    checks++; if (regRdData !== 64'h0) begin errors++;
      $display("FAIL R1: status actual=%h expected=0", regRdData); end
    checks++; if (irqOut !== 1'b0) begin errors++;
      $display("FAIL R1: irq actual=%b expected=0", irqOut); end
    regSel = 1'b1;
    #1;
    checks++; if (regRdData !== 64'h0) begin errors++;
      $display("FAIL R1: mask actual=%h expected=0", regRdData); end

    // R2 R3 R4: page fault capture and packing, masked so no irq (R9)
    doCycle(0, 0, '0, 1, 0, 23'h12345, 1, 11'h5A5, 0, "R2/R3/R4 page read capture");
    doCycle(0, 0, '0, 0, 0, '0, 0, '0, 1, "R9 mask zero no irq");
    // R8: only the two enable bits stick
    doCycle(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, '0, 0, '0, 1, "R8 mask write all ones");
    doCycle(0, 0, '0, 0, 0, '0, 0, '0, 0, "R9 page enable raises irq");
    // R5: held record ignores later faults
    doCycle(0, 0, '0, 1, 1, 23'h7FFFFF, 0, 11'h123, 0, "R5 later segment fault ignored");
    // R6: write with bit 63 set changes nothing
    doCycle(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, '0, 0, '0, 0, "R6 write with valid one ignored");
    // R6: clear
    doCycle(1, 0, 64'h0, 0, 0, '0, 0, '0, 0, "R6 clear keeps fields");
    // R3 R4: segment write fault with extreme fields
    doCycle(0, 0, '0, 1, 1, 23'h7FFFFF, 0, 11'h7FF, 0, "R3/R4 segment write capture");
    // R9: disable segment, keep page
    doCycle(1, 1, 64'h2000_0000_0000_0000, 0, 0, '0, 0, '0, 0, "R9 segment masked");
    doCycle(0, 0, '0, 0, 0, '0, 0, '0, 1, "R8 page only mask");
    // R7: clear and new fault in the same cycle
    doCycle(1, 0, 64'h0, 1, 0, 23'h00ABC, 1, 11'h001, 0, "R7 fault beside clear");
    // R9: change enable while page record held
    doCycle(1, 1, 64'h4000_0000_0000_0000, 0, 0, '0, 0, '0, 0, "R9 page disabled drops irq");
    // R6 then R2 with zero fields
    doCycle(1, 0, 64'h0, 0, 0, '0, 0, '0, 0, "R6 second clear");
    doCycle(0, 0, '0, 1, 1, 23'h0, 0, 11'h0, 0, "R2/R3 segment zero fields");
    doCycle(0, 0, '0, 0, 0, '0, 0, '0, 0, "R9 segment enabled irq");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule